// File: doc/BRIEF.md
# Serial Clock Generator with Prescaler

This block produces the serial clock of a two-wire bus controller from the module clock. A prescaler first divides the module clock by `P+1`, where `P` is the prescale setting. Two phase counters then time the clock: a low phase in which the block asks for SCL to be pulled low, and a high phase in which SCL is released. Each phase lasts its programmed count plus a fixed offset `d`, measured in prescaled ticks. The offset depends on the prescale setting: `d` is 7 for `P=0`, 6 for `P=1` and 5 for any larger `P`. With no stretching, one SCL period is therefore `(P+1)*((L+d)+(H+d))` module clocks, where `L` and `H` are the low and high settings. The prescaled rate is meant to sit between 7 and 12 MHz.

The protocol engine uses the block through two enables and two strobes. The generator runs only while the controller enable (`ctrl_en`) is high and the engine reports that it owns the bus (`bus_own`). Otherwise it sits idle with SCL released. The divider settings are changed only while `ctrl_en` is low, and `ctrl_en` stays low for at least one clock after a change. In the high phase the count advances only in cycles where the sampled bus line `scl_in` reads high, so a target that holds SCL low stretches the phase. The `change_tick` strobe marks the start of each low phase, where data may change. The `sample_tick` strobe marks the middle of the high phase, where data is sampled. `scl_in` is assumed to be already synchronous to `clk`. All outputs come straight from flip-flops.

Top module: `scl_clkgen`

## Requirements
- R1: After any clock edge at which `rst` is high, `ctrl_en` is low or `bus_own` is low, `scl_drive_low`, `change_tick` and `sample_tick` are all 0 for the next cycle.
- R2: The offset `d` is 7 when `psc_val` is 0, 6 when it is 1 and 5 when it is 2 or more. With `scl_in` following the released line, the distance between successive `change_tick` pulses is `(P+1)*((L+d)+(H+d))` clocks.
- R3: Each low phase keeps `scl_drive_low` at 1 for exactly `(L+d)*(P+1)` consecutive cycles.
- R4: A high phase keeps `scl_drive_low` at 0 and ends after `(H+d)*(P+1)` cycles in which `scl_in` was sampled as 1. The next low phase follows at once.
- R5: High-phase cycles with `scl_in` at 0 do not advance the count, so the high phase grows by exactly the number of such cycles.
- R6: `change_tick` is a one-cycle pulse in the first cycle of every low phase and is 0 in all other cycles.
- R7: `sample_tick` is a one-cycle pulse in the high-phase cycle that follows `floor((H+d)/2)*(P+1)` qualifying cycles of that phase. It is 0 in all other cycles.
- R8: From idle, when both enables are high at a clock edge, the next cycle is the first cycle of a low phase.
- R9: If `bus_own` drops in the middle of a phase, SCL is released in the next cycle. When `bus_own` returns, a full low phase starts again as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_en | input | 1 | Controller out of reset; 0 holds the generator idle |
| bus_own | input | 1 | Engine owns the bus; 0 releases SCL and idles the generator |
| psc_val | input | REG_W | Prescale setting P (divide by P+1) |
| low_val | input | REG_W | Low-phase setting L |
| high_val | input | REG_W | High-phase setting H |
| scl_in | input | 1 | Sampled SCL line level, synchronous to clk |
| scl_drive_low | output | 1 | 1 requests that SCL be pulled low |
| change_tick | output | 1 | Pulse at the start of each low phase |
| sample_tick | output | 1 | Pulse at the middle of each high phase |

## Verification
The bench builds the block with the default `REG_W=16`. It programs small low and high settings so that many whole periods fit in a short run. Prescale values 0, 1, 2 and 3 reach all three offset branches and both odd and even high-phase sums for the midpoint strobe. A prescale of 300 drives the divider's upper bits and long phases. A forced stretch of the line in the high phase, and a withdrawal of bus ownership during a low phase, test the pause and restart paths against the cycle model.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Fixed per-phase offset, chosen by the prescale setting.
  function automatic logic [3:0] phase_offset(input logic [31:0] psc);
    if (psc == 32'd0)      return 4'd7;
    else if (psc == 32'd1) return 4'd6;
    else                   return 4'd5;
  endfunction

endpackage

// File: rtl/scl_limit_calc.sv
module scl_limit_calc #(
  parameter int REG_W = 16,
  localparam int CNT_W = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] psc,
  input  logic [REG_W-1:0] low_val,
  input  logic [REG_W-1:0] high_val,
  output logic [CNT_W-1:0] low_term,
  output logic [CNT_W-1:0] high_term,
  output logic [CNT_W-1:0] half_term
);
  import scl_clkgen_pkg::*;

  logic [3:0]             ofs;
  logic [1:0][REG_W-1:0]  setting;
  logic [1:0][CNT_W-1:0]  span;
  logic [1:0][CNT_W-1:0]  term_q;
  logic [CNT_W-1:0]       half_q;

  assign ofs        = phase_offset(32'(psc));
  assign setting[0] = low_val;
  assign setting[1] = high_val;

  // One terminal count per phase: setting + offset - 1 ticks.
  for (genvar g = 0; g < 2; g++) begin : g_phase
    assign span[g] = CNT_W'(setting[g]) + CNT_W'(ofs);
    always_ff @(posedge clk) begin
      if (rst) term_q[g] <= '0;
      else     term_q[g] <= span[g] - CNT_W'(1);
    end
  end

  // Midpoint of the high phase, as a terminal count.
  always_ff @(posedge clk) begin
    if (rst) half_q <= '0;
    else     half_q <= (span[1] >> 1) - CNT_W'(1);
  end

  assign low_term  = term_q[0];
  assign high_term = term_q[1];
  assign half_term = half_q;

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [REG_W-1:0] psc,
  output logic             tick
);

  logic [REG_W-1:0] pcnt;

  assign tick = run && (pcnt == psc);

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else if (run)    pcnt <= pcnt + REG_W'(1);
  end

  // R3: the divider count never passes the prescale setting while running
  p_pcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (pcnt <= psc));

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             scl_in,
  input  logic             tick,
  input  logic [CNT_W-1:0] low_term,
  input  logic [CNT_W-1:0] high_term,
  input  logic [CNT_W-1:0] half_term,
  output logic             pre_clr,
  output logic             pre_run,
  output logic             drive_low,
  output logic             change_stb,
  output logic             sample_stb
);
  import scl_clkgen_pkg::*;

  phase_e           st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             chg_n, smp_n;
  logic             drive_q, chg_q, smp_q;

  // The prescaler runs through the low phase, and in the high phase
  // only while the line is seen high (stretching pauses it).
  assign pre_run = (st == PH_LOW) || ((st == PH_HIGH) && scl_in);
  assign pre_clr = !active || (st == PH_IDLE);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    chg_n = 1'b0;
    smp_n = 1'b0;
    if (!active) begin
      st_n  = PH_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st)
        PH_IDLE: begin
          st_n  = PH_LOW;
          cnt_n = '0;
          chg_n = 1'b1;
        end
        PH_LOW: begin
          if (tick) begin
            if (cnt == low_term) begin
              st_n  = PH_HIGH;
              cnt_n = '0;
            end else begin
              cnt_n = cnt + CNT_W'(1);
            end
          end
        end
        PH_HIGH: begin
          if (tick) begin
            if (cnt == half_term) smp_n = 1'b1;
            if (cnt == high_term) begin
              st_n  = PH_LOW;
              cnt_n = '0;
              chg_n = 1'b1;
            end else begin
              cnt_n = cnt + CNT_W'(1);
            end
          end
        end
        default: begin
          st_n  = PH_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      cnt     <= '0;
      drive_q <= 1'b0;
      chg_q   <= 1'b0;
      smp_q   <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      drive_q <= (st_n == PH_LOW);
      chg_q   <= chg_n;
      smp_q   <= smp_n;
    end
  end

  assign drive_low  = drive_q;
  assign change_stb = chg_q;
  assign sample_stb = smp_q;

  // R1: losing either enable quiets every output on the next cycle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!drive_q && !chg_q && !smp_q));

  // R6: every start of a low phase carries the change strobe
  p_change_marks_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_q) |-> chg_q);

  // R6: the change strobe lasts a single cycle
  p_change_single_r6: assert property (@(posedge clk) disable iff (rst)
    chg_q |=> !chg_q);

  // R7: the sample strobe only appears during a high phase
  p_sample_in_high_r7: assert property (@(posedge clk) disable iff (rst)
    smp_q |-> (st == PH_HIGH && !drive_q));

  // R5: a stretched line freezes the high-phase count
  p_stretch_pause_r5: assert property (@(posedge clk) disable iff (rst)
    (active && st == PH_HIGH && !scl_in) |=> $stable(cnt));

  // R3: the low-phase count stays within its terminal value
  p_low_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st == PH_LOW) |-> (cnt <= low_term));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int REG_W = 16,
  localparam int CNT_W = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_en,
  input  logic             bus_own,
  input  logic [REG_W-1:0] psc_val,
  input  logic [REG_W-1:0] low_val,
  input  logic [REG_W-1:0] high_val,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             change_tick,
  output logic             sample_tick
);

  logic             active;
  logic             tick, pre_clr, pre_run;
  logic [CNT_W-1:0] low_term, high_term, half_term;

  assign active = ctrl_en && bus_own;

  scl_limit_calc #(.REG_W(REG_W)) u_limits (
    .clk       (clk),
    .rst       (rst),
    .psc       (psc_val),
    .low_val   (low_val),
    .high_val  (high_val),
    .low_term  (low_term),
    .high_term (high_term),
    .half_term (half_term)
  );

  scl_prescaler #(.REG_W(REG_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .clr  (pre_clr),
    .run  (pre_run),
    .psc  (psc_val),
    .tick (tick)
  );

  scl_phase_ctl #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .scl_in     (scl_in),
    .tick       (tick),
    .low_term   (low_term),
    .high_term  (high_term),
    .half_term  (half_term),
    .pre_clr    (pre_clr),
    .pre_run    (pre_run),
    .drive_low  (scl_drive_low),
    .change_stb (change_tick),
    .sample_stb (sample_tick)
  );

endmodule

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;

  localparam int REG_W = 16;
  localparam int WATCHDOG = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ctrl_en = 1'b0;
  logic             bus_own = 1'b0;
  logic [REG_W-1:0] psc_val = '0;
  logic [REG_W-1:0] low_val = '0;
  logic [REG_W-1:0] high_val = '0;
  logic             stretch = 1'b0;
  logic             scl_in;
  logic             scl_drive_low, change_tick, sample_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  // Wired bus: the line is low when driven or held by a stretching target.
  assign scl_in = !scl_drive_low && !stretch;

  scl_clkgen #(.REG_W(REG_W)) i_scl_clkgen (
    .clk           (clk),
    .rst           (rst),
    .ctrl_en       (ctrl_en),
    .bus_own       (bus_own),
    .psc_val       (psc_val),
    .low_val       (low_val),
    .high_val      (high_val),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .change_tick   (change_tick),
    .sample_tick   (sample_tick)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int offs(input int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  // ---------------- cycle reference model ----------------
  int    m_ph = 0;   // 0 idle, 1 low, 2 high
  int    m_n  = 0;   // qualifying cycles spent in the current phase
  bit    e_drv = 0, e_chg = 0, e_smp = 0;
  bit    model_on = 0;
  string e_tag = "R1";

  always @(posedge clk) begin
    int p, d, lc, hc, hf;
    p  = int'(psc_val);
    d  = offs(p);
    lc = (int'(low_val) + d) * (p + 1);
    hc = (int'(high_val) + d) * (p + 1);
    hf = ((int'(high_val) + d) / 2) * (p + 1);
    e_chg = 0;
    e_smp = 0;
    if (rst || !ctrl_en || !bus_own) begin
      m_ph = 0;
      m_n  = 0;
    end else if (m_ph == 0) begin
      m_ph  = 1;
      m_n   = 0;
      e_chg = 1;
    end else if (m_ph == 1) begin
      m_n++;
      if (m_n == lc) begin
        m_ph = 2;
        m_n  = 0;
      end
    end else if (scl_in) begin
      m_n++;
      if (m_n == hf) e_smp = 1;
      if (m_n == hc) begin
        m_ph  = 1;
        m_n   = 0;
        e_chg = 1;
      end
    end
    e_drv = (m_ph == 1);
    e_tag = (m_ph == 0) ? "R1" : (m_ph == 1) ? "R3" : (stretch ? "R5" : "R4");
    if (!rst) model_on = 1;
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      check(e_tag, "model scl_drive_low", int'(scl_drive_low), int'(e_drv));
      check("R6", "model change_tick", int'(change_tick), int'(e_chg));
      check("R7", "model sample_tick", int'(sample_tick), int'(e_smp));
    end
  end

  // ---------------- directed sequences ----------------
  task automatic configure(input int p, input int l, input int h);
    @(negedge clk);
    ctrl_en  = 1'b0;
    psc_val  = REG_W'(p);
    low_val  = REG_W'(l);
    high_val = REG_W'(h);
    repeat (3) @(negedge clk);
    check("R1", "idle drive while held", int'(scl_drive_low), 0);
    ctrl_en = 1'b1;
    bus_own = 1'b1;
    @(negedge clk);
    check("R8", "change_tick after enable", int'(change_tick), 1);
    check("R8", "drive after enable", int'(scl_drive_low), 1);
  endtask

  // Called at a negedge where change_tick is high; measures one period.
  task automatic measure(input int p, input int l, input int h);
    int d, n, m;
    d = offs(p);
    n = 0;
    while (scl_drive_low) begin
      n++;
      @(negedge clk);
      if (n == 1) check("R6", "change_tick width", int'(change_tick), 0);
    end
    check("R3", "low phase length", n, (l + d) * (p + 1));
    m = 0;
    while (!sample_tick) begin
      m++;
      @(negedge clk);
    end
    check("R7", "sample delay into high", m, ((h + d) / 2) * (p + 1));
    while (!change_tick) begin
      m++;
      @(negedge clk);
    end
    check("R4", "high phase length", m, (h + d) * (p + 1));
    check("R2", "period", n + m, (p + 1) * ((l + d) + (h + d)));
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    ctrl_en = 1'b1;
    bus_own = 1'b1;
    @(negedge clk);
    check("R1", "reset drive", int'(scl_drive_low), 0);
    check("R1", "reset change_tick", int'(change_tick), 0);
    check("R1", "reset sample_tick", int'(sample_tick), 0);
    rst = 1'b0;

    configure(0, 3, 4);   measure(0, 3, 4);  measure(0, 3, 4);
    configure(1, 2, 2);   measure(1, 2, 2);
    configure(2, 5, 1);   measure(2, 5, 1);
    configure(3, 0, 0);   measure(3, 0, 0);
    configure(300, 0, 1); measure(300, 0, 1);

    // R5: stretch the line for five cycles at the start of the high phase
    configure(1, 1, 1);
    while (scl_drive_low) @(negedge clk);
    stretch = 1'b1;
    k = 0;
    repeat (5) begin
      k++;
      @(negedge clk);
      check("R5", "stretched phase keeps line released", int'(scl_drive_low), 0);
    end
    stretch = 1'b0;
    while (!change_tick) begin
      k++;
      @(negedge clk);
    end
    check("R5", "stretched high length", k, (1 + 6) * 2 + 5);

    // R9: withdraw bus ownership mid low phase, then restore it
    repeat (3) @(negedge clk);
    while (!scl_drive_low) @(negedge clk);
    bus_own = 1'b0;
    @(negedge clk);
    check("R9", "release after ownership loss", int'(scl_drive_low), 0);
    check("R9", "no change strobe while released", int'(change_tick), 0);
    repeat (4) @(negedge clk);
    bus_own = 1'b1;
    @(negedge clk);
    check("R9", "restart change_tick", int'(change_tick), 1);
    measure(1, 1, 1);

    // R1: dropping the controller enable idles the generator
    ctrl_en = 1'b0;
    @(negedge clk);
    check("R1", "idle after enable drop", int'(scl_drive_low), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule